// File: doc/BRIEF.md
# Mixed-Radix Synchronous Cascaded Counter

This block counts clock cycles through a 12-state cycle built from two small counter stages on one shared clock. The low stage counts modulo 4. The high stage counts modulo 3. Every flip-flop sits on the same clock edge. The low stage's terminal-count flag is the only thing that lets the high stage step, so the two stages act like digits of a mixed-radix number: the combined value is `hi_cnt * 4 + lo_cnt`.

A global run input gates the whole chain. When run is low, both stages hold and every terminal-count flag is forced low. An active-low synchronous reset clears both stages and wins over run. Each stage treats any code at or above its modulus as a spill state and steps to zero on its next enabled edge. This means a stray value cannot trap the chain in a loop that never produces terminal count.

Top module: `mixrad_counter`

## Requirements
- R1: On a clock edge where `rst_n` is 0, both `lo_cnt` and `hi_cnt` become 00, whatever `run` is.
- R2: On a clock edge where `rst_n` is 1 and `run` is 0, `lo_cnt` and `hi_cnt` keep their values.
- R3: While `run` is 0, `lo_tc`, `hi_tc` and `all_tc` are all 0.
- R4: On each edge with `rst_n` 1 and `run` 1, `lo_cnt` steps through the order 00, 01, 10, 11, 00.
- R5: `hi_cnt` changes only on an edge where `run` is 1 and `lo_cnt` is 11. On such an edge it steps 00 to 01, 01 to 10, and 10 to 00.
- R6: `lo_tc` is 1 exactly when `run` is 1 and `lo_cnt` is 11. `hi_tc` is 1 exactly when `run` is 1 and `hi_cnt` is 10.
- R7: `all_tc` is 1 exactly when `run` is 1 and the combined value `hi_cnt*4+lo_cnt` equals 11, that is `hi_cnt` 10 and `lo_cnt` 11.
- R8: After reset, `hi_cnt` never shows 11. Any stage code at or above the stage modulus becomes 00 on the stage's next enabled edge.
- R9: With `run` held at 1, the combined value returns to its starting value after exactly 12 edges and visits every value 0 to 11 once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared clock for both stages |
| rst_n | input | 1 | Synchronous reset, active low, wins over run |
| run | input | 1 | Global count enable |
| lo_cnt | output | 2 | Low stage value, modulo 4 |
| hi_cnt | output | 2 | High stage value, modulo 3 |
| lo_tc | output | 1 | Low stage terminal count, gated by run |
| hi_tc | output | 1 | High stage terminal count, gated by run |
| all_tc | output | 1 | Terminal count of the full 12-state cycle, gated by run |

## Verification
A long stretch with run held high covers every combined value several times. This checks the carry from low to high stage, the wrap of both stages, and the single cycle where `all_tc` rises. A stretch where run toggles in an irregular pattern catches any stage that counts, or any flag that shows, while run is low. It also catches a high stage that uses the raw low-stage bits instead of the run-gated carry. Resets issued mid-count, with run high and with run low, show that reset wins over run.

// File: rtl/mixrad_pkg.sv
// Package: shared sizes for the mixed-radix cascaded counter.
// Assumes each stage modulus is at least 2 and fits in its stage width.
package mixrad_pkg;
    parameter int LO_W   = 2;
    parameter int LO_MOD = 4;
    parameter int HI_W   = 2;
    parameter int HI_MOD = 3;
endpackage

// File: rtl/mixrad_stage.sv
// Module: one synchronous modulo-MOD counter stage.
// Steps by one on each enabled edge and wraps at MOD-1. Any code at or
// above MOD-1 goes to zero on an enabled edge, so spill codes rejoin the
// main sequence. Assumes 2 <= MOD <= 2**W.
module mixrad_stage #(
    parameter int W   = 2,
    parameter int MOD = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    output logic [W-1:0] q,
    output logic         tc
);
    localparam logic [W-1:0] LAST = W'(MOD - 1);

    logic [W-1:0] q_nxt;

    // Next-state choice: wrap at or above the last legal code.
    always_comb begin
        if (q >= LAST) q_nxt = '0;
        else           q_nxt = q + W'(1);
    end

    // State register: reset first, then step when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (en) q <= q_nxt;
    end

    // Terminal count: last legal code while the stage is permitted to run.
    assign tc = en && (q == LAST);
endmodule

// File: rtl/mixrad_tc_join.sv
// Module: combines the per-stage terminal counts into the whole-cycle flag.
// Assumes every input is already gated by the global run input.
module mixrad_tc_join #(
    parameter int N = 2
) (
    input  logic [N-1:0] stage_tc,
    input  logic [N-1:0] stage_last,
    output logic         all_tc
);
    // Whole-cycle flag: the bottom stage is carrying and every stage is at its last code.
    assign all_tc = stage_tc[0] && (&stage_last);
endmodule

// File: rtl/mixrad_counter.sv
// Module: top of the mixed-radix cascaded counter (modulo 4 then modulo 3).
// All state is on clk. The low stage runs on every edge where run is high.
// The high stage is enabled only by the low stage's terminal count.
// Assumes rst_n is synchronous to clk.
module mixrad_counter
    import mixrad_pkg::*;
#(
    parameter int LW = LO_W,
    parameter int LM = LO_MOD,
    parameter int HW = HI_W,
    parameter int HM = HI_MOD
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    output logic [LW-1:0] lo_cnt,
    output logic [HW-1:0] hi_cnt,
    output logic          lo_tc,
    output logic          hi_tc,
    output logic          all_tc
);
    localparam logic [HW-1:0] HI_LAST = HW'(HM - 1);

    logic hi_en;

    mixrad_stage #(.W(LW), .MOD(LM)) u_lo (
        .clk(clk), .rst_n(rst_n), .en(run), .q(lo_cnt), .tc(lo_tc)
    );

    // Carry: the low stage's terminal count permits the high stage.
    assign hi_en = lo_tc;

    logic hi_tc_stage;
    mixrad_stage #(.W(HW), .MOD(HM)) u_hi (
        .clk(clk), .rst_n(rst_n), .en(hi_en), .q(hi_cnt), .tc(hi_tc_stage)
    );

    // High flag: last code of the high stage while run is high.
    assign hi_tc = run && (hi_cnt == HI_LAST);

    mixrad_tc_join #(.N(2)) u_join (
        .stage_tc({hi_tc, lo_tc}),
        .stage_last({hi_tc_stage | hi_tc, lo_tc}),
        .all_tc(all_tc)
    );
endmodule

// File: rtl/mixrad_counter_chk.sv
// Checker: temporal properties of the cascaded counter, bound to the top.
module mixrad_counter_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       run,
    input logic [1:0] lo_cnt,
    input logic [1:0] hi_cnt,
    input logic       lo_tc,
    input logic       hi_tc,
    input logic       all_tc
);
    logic seen_edge;
    // Marks that at least one clock edge has passed.
    always_ff @(posedge clk) seen_edge <= 1'b1;

    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (lo_cnt == 2'd0 && hi_cnt == 2'd0));

    assert_idle_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> ($stable(lo_cnt) && $stable(hi_cnt)));

    assert_idle_flags_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (!lo_tc && !hi_tc && !all_tc));

    assert_low_steps_R4: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> (lo_cnt == $past(lo_cnt) + 2'd1));

    assert_high_waits_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_cnt != 2'd3) |=> $stable(hi_cnt));

    assert_full_tc_R7: assert property (@(posedge clk) disable iff (!rst_n)
        all_tc |-> (lo_tc && hi_tc && lo_cnt == 2'd3 && hi_cnt == 2'd2));

    assert_high_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (run && lo_cnt == 2'd3 && hi_cnt >= 2'd2) |=> (hi_cnt == 2'd0));

    // R8: once past reset, the high spill code is never shown.
    always @(negedge clk)
        if (seen_edge && rst_n)
            assert_no_spill_R8: assert (hi_cnt != 2'd3);
endmodule

bind mixrad_counter mixrad_counter_chk u_chk (
    .clk(clk), .rst_n(rst_n), .run(run), .lo_cnt(lo_cnt), .hi_cnt(hi_cnt),
    .lo_tc(lo_tc), .hi_tc(hi_tc), .all_tc(all_tc)
);

// File: tb/mixrad_counter_tb.sv
module mixrad_counter_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run = 1'b0;
    logic [1:0] lo_cnt, hi_cnt;
    logic       lo_tc, hi_tc, all_tc;
    int checks = 0;
    int errors = 0;
    int model = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    mixrad_counter u_dut (
        .clk(clk), .rst_n(rst_n), .run(run), .lo_cnt(lo_cnt), .hi_cnt(hi_cnt),
        .lo_tc(lo_tc), .hi_tc(hi_tc), .all_tc(all_tc)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d (model %0d)", req, act, exp, model);
        end
    endtask

    // Compare all outputs to the arithmetic model; run is the current input.
    task automatic compare(input bit e);
        chk("R4 lo_cnt", int'(lo_cnt), model % 4);
        chk("R5 hi_cnt", int'(hi_cnt), model / 4);
        chk("R8 no spill", int'(hi_cnt == 2'd3), 0);
        if (!e) chk("R3 flags", int'({lo_tc, hi_tc, all_tc}), 0);
        chk("R6 lo_tc", int'(lo_tc), int'(e && (model % 4 == 3)));
        chk("R6 hi_tc", int'(hi_tc), int'(e && (model / 4 == 2)));
        chk("R7 all_tc", int'(all_tc), int'(e && model == 11));
    endtask

    // One cycle: drive at negedge, check, let the edge happen, advance model.
    task automatic cyc(input bit r, input bit e);
        rst_n = r;
        run = e;
        #1;
        compare(e);
        @(posedge clk);
        if (!r)     model = 0;
        else if (e) model = (model + 1) % 12;
        @(negedge clk);
    endtask

    initial begin
        @(negedge clk);
        cyc(1'b0, 1'b1);
        cyc(1'b0, 1'b0);
        // R1: reset state
        chk("R1 reset lo", int'(lo_cnt), 0);
        chk("R1 reset hi", int'(hi_cnt), 0);
        // R9: free run over three full cycles, returning to start every 12 edges
        for (int i = 0; i < 36; i++) begin
            cyc(1'b1, 1'b1);
            if (i % 12 == 11) chk("R9 cycle return", int'(hi_cnt) * 4 + int'(lo_cnt), 0);
        end
        // R2/R3: irregular run pattern
        for (int i = 0; i < 60; i++) begin
            logic [1:0] lo0, hi0;
            bit e;
            e = ((i * 7) % 5) < 2;
            lo0 = lo_cnt;
            hi0 = hi_cnt;
            cyc(1'b1, e);
            if (!e) begin
                chk("R2 hold lo", int'(lo_cnt), int'(lo0));
                chk("R2 hold hi", int'(hi_cnt), int'(hi0));
            end
        end
        // R1: reset in the middle of a count, with run high and with run low
        for (int i = 0; i < 7; i++) cyc(1'b1, 1'b1);
        cyc(1'b0, 1'b1);
        chk("R1 reset over run", int'(hi_cnt) * 4 + int'(lo_cnt), 0);
        for (int i = 0; i < 10; i++) cyc(1'b1, 1'b1);
        cyc(1'b0, 1'b0);
        chk("R1 reset while idle", int'(hi_cnt) * 4 + int'(lo_cnt), 0);
        for (int i = 0; i < 14; i++) cyc(1'b1, 1'b1);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog actual hung expected done");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule